// File: doc/BRIEF.md
# Comparator Fault Status Capture Register

This block turns two asynchronous comparator fault inputs into an 8-bit status byte that a register read port can return. Each comparator has a live bit, which follows its input after synchronization, and a captured bit, which takes a snapshot of both live bits when a chosen trigger event occurs. The captured bits then stay as they are until the next trigger, or until software clears them.

A single configuration bit picks the trigger source. The first option is the block's own fault output going active; that output is active low. The second option is a shared, bidirectional ready line being pulled low by another device. When several devices share the ready line, all of them freeze their comparator states on the same edge.

With the ready-line trigger selected, the block releases its ready driver so the line works as an input. Otherwise the block drives the ready line, and the line reports whether the controlled supply is at its set point. Captured bits are cleared by a write strobe with write-one-to-clear data.

Top module: `cmp_status_latch`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, `status` reads 0x00.
- R2: `status[1:0]` show comparators 1 and 0 (1 = fault). A change on `cmp_raw` appears there two clock edges after it is applied.
- R3: `status[7:4]` always read zero. Clear-strobe data in bits 0, 1 and 4 to 7 changes no status bit.
- R4: With `evt_sel` = 0, a falling edge on `fault_n` copies `status[1:0]` into `status[3:2]`. The result is visible three clock edges after the edge is applied.
- R5: With `evt_sel` = 1, a falling edge on `rdy_in` performs the same copy, with the same three-edge latency.
- R6: An edge on the trigger source that is not selected leaves `status[3:2]` unchanged.
- R7: A capture is taken only on the edge of the trigger. Holding the trigger active does not capture again when the comparators change.
- R8: A one-cycle `clr_stb` with `clr_mask[2]` or `clr_mask[3]` set clears the matching captured bit on the next edge. The live bits are not affected.
- R9: When a capture and a clear fall on the same edge, the capture wins.
- R10: With `evt_sel` = 0, `rdy_oe` is 1 and `rdy_out` follows `at_setpoint`. With `evt_sel` = 1, `rdy_oe` is 0. Both relations are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw | input | 2 | Asynchronous comparator fault inputs, 1 = fault |
| evt_sel | input | 1 | Trigger select: 0 = fault output asserted, 1 = ready line pulled low |
| fault_n | input | 1 | Fault output as seen at its pin, active low, asynchronous |
| rdy_in | input | 1 | Ready line as seen at its pin, asynchronous |
| at_setpoint | input | 1 | Controlled supply is at its set point |
| clr_stb | input | 1 | Status write strobe, one cycle |
| clr_mask | input | 8 | Write-one-to-clear data for the status byte |
| status | output | 8 | Status byte: [1:0] live, [3:2] captured, [7:4] zero |
| rdy_out | output | 1 | Value driven onto the ready line |
| rdy_oe | output | 1 | Ready line driver enable |

## Verification
The results arrive on different schedules. Live bits move two edges after a comparator change. A capture shows three edges after the trigger edge: two synchronizer edges plus the capture register. A clear takes effect on the edge after the strobe, and the ready driver outputs follow with no register at all. The driver task records each expected status value together with the cycle count at which it becomes due. The monitor compares only at that cycle, on the falling clock edge. Some checks are also placed one cycle early, so that a result arriving too soon is caught as well.

// File: rtl/cmp_status_pkg.sv
// Package: shared types and field layout for the comparator status capture block.
// Assumes two comparators and an 8-bit status byte unless the top overrides them.
package cmp_status_pkg;

    // Trigger source selected by the configuration bit
    typedef enum logic {
        TRIG_FAULT = 1'b0,
        TRIG_READY = 1'b1
    } trig_src_e;

    localparam int NUM_TRIG = 2;

endpackage

// File: rtl/cmp_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent. Reset loads a chosen idle value so that no
// false edge is seen downstream when reset is released.
module cmp_sync #(
    parameter int           WIDTH   = 1,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/cmp_trig_detect.sv
// Module: detects the activation edge of each trigger source and forwards the
// edge of the selected source as a one-cycle capture pulse.
// Assumes the inputs are already synchronized and active high.
module cmp_trig_detect
    import cmp_status_pkg::*;
#(
    parameter int N_SRC = NUM_TRIG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] trig_act,
    input  logic             sel,
    output logic             cap_pulse
);

    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] rise;

    // Remember the previous level of every source
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= trig_act;
    end

    // One rising-edge detector per source
    for (genvar g = 0; g < N_SRC; g++) begin : g_edge
        assign rise[g] = trig_act[g] & ~prev_q[g];
    end

    // Route the selected source's edge to the capture pulse
    always_comb begin
        cap_pulse = rise[sel];
    end

endmodule

// File: rtl/cmp_status_reg.sv
// Module: status byte with live comparator bits and captured copies.
// A capture loads the live bits. A clear applies write-one-to-clear to the captured
// field only, and a capture on the same edge takes priority over the clear.
module cmp_status_reg #(
    parameter int N_CMP  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CMP-1:0]  live,
    input  logic              cap_pulse,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] status
);

    localparam int LAT_LO = N_CMP;
    localparam int LAT_HI = 2 * N_CMP - 1;
    localparam logic [DATA_W-1:0] LAT_FIELD = {{(DATA_W-N_CMP){1'b0}}, {N_CMP{1'b1}}} << LAT_LO;

    logic [N_CMP-1:0] lat_q;
    logic             unused_mask_bits;

    // Capture on the selected event, otherwise apply the write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)         lat_q <= '0;
        else if (cap_pulse) lat_q <= live;
        else if (clr_stb)   lat_q <= lat_q & ~clr_mask[LAT_HI:LAT_LO];
    end

    // Mask bits outside the captured field have no function
    assign unused_mask_bits = ^(clr_mask & ~LAT_FIELD);

    // Assemble the readable byte; the upper bits are constant zero
    always_comb begin
        status                = '0;
        status[N_CMP-1:0]     = live;
        status[LAT_HI:LAT_LO] = lat_q;
    end

endmodule

// File: rtl/cmp_status_latch.sv
// Module (top): comparator fault status with trigger-selected capture.
// Synchronizes the comparator, fault and ready inputs, picks the capture trigger
// and drives the ready line only while that line is not used as a trigger.
// Assumes fault_n is active low and that the ready line idles high.
module cmp_status_latch
    import cmp_status_pkg::*;
#(
    parameter int N_CMP       = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CMP-1:0]  cmp_raw,
    input  logic              evt_sel,
    input  logic              fault_n,
    input  logic              rdy_in,
    input  logic              at_setpoint,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] status,
    output logic              rdy_out,
    output logic              rdy_oe
);

    logic [N_CMP-1:0]    cmp_sy;
    logic [1:0]          pin_sy;
    logic [NUM_TRIG-1:0] trig_act;
    logic                cap_pulse;
    trig_src_e           src;

    // Comparator inputs: idle value is "no fault"
    cmp_sync #(.WIDTH(N_CMP), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_cmp_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(cmp_raw),
        .q_sync (cmp_sy)
    );

    // Fault and ready pins: both idle high
    cmp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_pin_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({rdy_in, fault_n}),
        .q_sync (pin_sy)
    );

    // Convert both triggers to active-high levels, indexed by trigger source
    always_comb begin
        src                  = trig_src_e'(evt_sel);
        trig_act[TRIG_FAULT] = ~pin_sy[0];
        trig_act[TRIG_READY] = ~pin_sy[1];
    end

    cmp_trig_detect #(.N_SRC(NUM_TRIG)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_act (trig_act),
        .sel      (evt_sel),
        .cap_pulse(cap_pulse)
    );

    cmp_status_reg #(.N_CMP(N_CMP), .DATA_W(DATA_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (cmp_sy),
        .cap_pulse(cap_pulse),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .status   (status)
    );

    // Ready driver: enabled only while the line is not a trigger input
    always_comb begin
        rdy_oe  = (src == TRIG_FAULT);
        rdy_out = at_setpoint;
    end

endmodule

// File: rtl/cmp_status_latch_chk.sv
// Checker: temporal properties of the comparator status block, bound to the top.
module cmp_status_latch_chk #(
    parameter int N_CMP       = 2,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CMP-1:0]  cmp_raw,
    input logic              evt_sel,
    input logic              clr_stb,
    input logic [DATA_W-1:0] clr_mask,
    input logic [DATA_W-1:0] status,
    input logic              rdy_oe,
    input logic              cap_pulse
);

    logic [3:0] age_q;

    // Count edges since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 4'hF) age_q <= age_q + 4'd1;
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[DATA_W-1:2*N_CMP] == '0);                                     // R3

    AST_LIVE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q > SYNC_STAGES) |-> status[N_CMP-1:0] == $past(cmp_raw, SYNC_STAGES)); // R2

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> status[2*N_CMP-1:N_CMP] == $past(status[N_CMP-1:0]));  // R4

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_pulse && !clr_stb) |=> $stable(status[2*N_CMP-1:N_CMP]));      // R7

    AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !cap_pulse && clr_mask[N_CMP]) |=> !status[N_CMP]);     // R8

    AST_READY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sel |-> !rdy_oe);                                                // R10

endmodule

bind cmp_status_latch cmp_status_latch_chk #(
    .N_CMP(N_CMP), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_raw  (cmp_raw),
    .evt_sel  (evt_sel),
    .clr_stb  (clr_stb),
    .clr_mask (clr_mask),
    .status   (status),
    .rdy_oe   (rdy_oe),
    .cap_pulse(cap_pulse)
);

// File: tb/cmp_status_latch_test.sv
// Scoreboard bench: stimulus pushes timed expectations, monitor compares on falling edges.
module cmp_status_latch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = 2'b00;
    logic       evt_sel = 1'b0;
    logic       fault_n = 1'b1;
    logic       rdy_in = 1'b1;
    logic       at_setpoint = 1'b0;
    logic       clr_stb = 1'b0;
    logic [7:0] clr_mask = 8'h00;
    logic [7:0] status;
    logic       rdy_out;
    logic       rdy_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int         due;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    cmp_status_latch uut (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .evt_sel(evt_sel),
        .fault_n(fault_n), .rdy_in(rdy_in), .at_setpoint(at_setpoint),
        .clr_stb(clr_stb), .clr_mask(clr_mask), .status(status),
        .rdy_out(rdy_out), .rdy_oe(rdy_oe)
    );

    task automatic expect_at(input int delay, input logic [7:0] val, input string req);
        exp_t e;
        e.due = cyc + delay;
        e.val = val;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk1(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Monitor: compare every expectation that has come due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (status !== it.val) begin
                errors++;
                $display("FAIL %s: status got %h expected %h (cycle %0d)", it.req, status, it.val, cyc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(3);
        checks++;
        if (status !== 8'h00) begin
            errors++;
            $display("FAIL R1: got %h expected 00", status);
        end
        rst_n = 1'b1;
        expect_at(0, 8'h00, "R1");
        expect_at(2, 8'h00, "R1");
        wait_cyc(3);

        // R10: ready driver in fault-trigger mode
        at_setpoint = 1'b1;
        #1;
        chk1(rdy_oe, 1'b1, "R10");
        chk1(rdy_out, 1'b1, "R10");
        at_setpoint = 1'b0;
        #1;
        chk1(rdy_out, 1'b0, "R10");
        wait_cyc(1);

        // R2: live bit latency
        cmp_raw = 2'b01;
        expect_at(1, 8'h00, "R2");
        expect_at(2, 8'h01, "R2");
        wait_cyc(4);

        // R4: fault output asserted captures live bits
        fault_n = 1'b0;
        expect_at(2, 8'h01, "R4");
        expect_at(3, 8'h05, "R4");
        wait_cyc(5);

        // R7: held trigger does not capture again
        cmp_raw = 2'b10;
        expect_at(2, 8'h06, "R7");
        expect_at(6, 8'h06, "R7");
        wait_cyc(7);

        // R3: mask bits outside the captured field change nothing
        clr_stb = 1'b1;
        clr_mask = 8'hF3;
        expect_at(1, 8'h06, "R3");
        wait_cyc(1);
        clr_stb = 1'b0;
        wait_cyc(2);

        // R8: write-one-to-clear on bit 2, live bits untouched
        clr_stb = 1'b1;
        clr_mask = 8'h04;
        expect_at(1, 8'h02, "R8");
        wait_cyc(1);
        clr_stb = 1'b0;
        wait_cyc(2);

        // R6: ready-line edge ignored in fault-trigger mode
        rdy_in = 1'b0;
        expect_at(4, 8'h02, "R6");
        wait_cyc(5);
        rdy_in = 1'b1;
        wait_cyc(4);

        // R5: ready-line trigger mode
        fault_n = 1'b1;
        evt_sel = 1'b1;
        #1;
        chk1(rdy_oe, 1'b0, "R10");
        wait_cyc(4);
        rdy_in = 1'b0;
        expect_at(2, 8'h02, "R5");
        expect_at(3, 8'h0A, "R5");
        wait_cyc(4);

        // R6: fault edge ignored in ready-trigger mode
        cmp_raw = 2'b11;
        fault_n = 1'b0;
        expect_at(5, 8'h0B, "R6");
        wait_cyc(6);

        // R9: capture and clear on the same edge, capture wins
        rdy_in = 1'b1;
        wait_cyc(4);
        rdy_in = 1'b0;
        wait_cyc(2);
        clr_stb = 1'b1;
        clr_mask = 8'h0C;
        expect_at(1, 8'h0F, "R9");
        wait_cyc(1);
        clr_stb = 1'b0;
        expect_at(1, 8'h0F, "R9");
        wait_cyc(3);

        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule